// File: doc/BRIEF.md
# I2C Host Buffer with Status Flags and Byte CRC

This block sits between a CPU register interface and the bit-level shifter of an I2C slave/master controller. It buffers one outgoing byte and one incoming byte, and keeps the status flags that software polls. These flags record the slave transfer direction, whether the last ninth-clock sample was a no-acknowledge, whether a fresh CRC byte is waiting, whether the transmit buffer is free, and whether the receive buffer holds unread data. When the shifter asks for a byte, the buffered transmit byte moves into it. When the shifter delivers a byte, that byte lands in the receive buffer.

Every byte that crosses the bus, including the address byte, feeds a running CRC-8. One clock after each byte event, the updated CRC is published in a CRC register and a ready flag is raised. To send the CRC, software reads the CRC register and writes that value back through the transmit buffer. SCL/SDA timing, START/STOP detection and arbitration are handled by the shifter and are not part of this block.

Top module: `iic_hostbuf`

## Requirements
- R1: After reset, txEmpty=1, noAck=1, rxFull=0, crcReady=0, dirTx=0, sdaRelease=0, shTxValid=0, underrun=0, overrun=0, and rxData, crcData and shTxByte are 0.
- R2: On a shAddrMatch pulse, dirTx takes the value of shRwBit (1 = master reads, slave transmits; 0 = master writes, slave receives). In any other cycle dirTx holds.
- R3: On a shAckSample pulse, noAck takes the sampled shNack level (1 = no acknowledge seen at the ninth clock, 0 = acknowledge seen). In any other cycle noAck holds.
- R4: sdaRelease sets on a shAckSample pulse with shNack=1. It clears on a shStart pulse or on a shAckSample pulse with shNack=0, and the set takes priority.
- R5: A cpuWrTx strobe loads cpuWdata into the transmit buffer and clears txEmpty. A shLoadReq while txEmpty=0 copies the buffer to shTxByte, pulses shTxValid for one cycle and sets txEmpty. If both happen in the same cycle, txEmpty ends at 1.
- R6: A shLoadReq while txEmpty=1 pulses underrun for one cycle. shTxByte is left unchanged and shTxValid stays 0.
- R7: A shByteRcvd pulse stores shRxByte in rxData and sets rxFull. A cpuRdRx strobe clears rxFull. If both happen in the same cycle, rxFull ends at 1.
- R8: A shByteRcvd pulse while rxFull=1 still overwrites rxData and pulses overrun for one cycle.
- R9: The running CRC is CRC-8 with polynomial 0x07 (x^8+x^2+x+1), initial value 0x00, shifted MSB first. It covers the byte on shRxByte at shAddrMatch or shByteRcvd, and the current shTxByte at shByteSent. A shStart pulse resets the running value to 0x00.
- R10: crcData and crcReady update on the second clock edge after a byte-event pulse. At the first edge, neither output has changed yet.
- R11: A cpuRdCrc strobe clears crcReady. A CRC publish in the same cycle wins, leaving crcReady at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWrTx | input | 1 | CPU write strobe for the transmit buffer |
| cpuWdata | input | 8 | CPU write data |
| cpuRdRx | input | 1 | CPU read strobe for the receive buffer |
| cpuRdCrc | input | 1 | CPU read strobe for the CRC register |
| rxData | output | 8 | Receive buffer contents |
| crcData | output | 8 | Published CRC byte |
| dirTx | output | 1 | Slave direction, 1 = slave transmits |
| noAck | output | 1 | Last ninth-clock sample was no-acknowledge |
| crcReady | output | 1 | New CRC byte available |
| txEmpty | output | 1 | Transmit buffer free |
| rxFull | output | 1 | Receive buffer holds unread data |
| shStart | input | 1 | Start-of-transfer pulse from the shifter |
| shLoadReq | input | 1 | Shifter requests the next outgoing byte |
| shTxByte | output | 8 | Byte handed to the shifter |
| shTxValid | output | 1 | One-cycle pulse when shTxByte is loaded |
| shByteSent | input | 1 | Shifter finished sending shTxByte |
| shByteRcvd | input | 1 | Shifter delivers a data byte on shRxByte |
| shRxByte | input | 8 | Byte from the shifter |
| shAddrMatch | input | 1 | Address byte on shRxByte matched |
| shRwBit | input | 1 | R/W bit of the matched address |
| shAckSample | input | 1 | Ninth-clock acknowledge sample strobe |
| shNack | input | 1 | Sampled level, 1 = no acknowledge |
| sdaRelease | output | 1 | Request the shifter to let SDA go |
| underrun | output | 1 | One-cycle pulse: load request with an empty buffer |
| overrun | output | 1 | One-cycle pulse: unread receive byte overwritten |

## Verification
A cycle-accurate reference model runs against thousands of cycles of seeded random stimulus. In this stimulus, CPU strobes and shifter events often land in the same cycle, so every set-against-clear collision on txEmpty, rxFull, crcReady and sdaRelease occurs many times. That separates a set-priority rule from a clear-priority rule.

Directed cases cover further points:
- A known address byte (0x01 gives CRC 0x07) checks the one-cycle publish delay and separates a correct polynomial and bit order from a wrong one.
- Load requests against an empty buffer check underrun.
- Back-to-back received bytes check overwrite and overrun.
- A start pulse placed between bytes shows whether the running CRC is cleared rather than carried across transfers.

// File: rtl/iic_hostbuf_pkg.sv
package iic_hostbuf_pkg;

  // Which byte feeds the CRC stage register
  typedef enum logic {
    SRC_RX = 1'b0,
    SRC_TX = 1'b1
  } stageSrc_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic      txLoad;     // CPU data into transmit buffer
    logic      txMove;     // transmit buffer into shifter register
    logic      rxCapture;  // shifter byte into receive buffer
    logic      stageLoad;  // capture a byte for CRC
    stageSrc_t stageSrc;
    logic      crcCommit;  // publish stage result
    logic      crcClear;   // restart running CRC
  } hbStrobes_t;

endpackage

// File: rtl/iic_hostbuf_dp.sv
module iic_hostbuf_dp
  import iic_hostbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CRC_POLY = 8'h07,
  parameter logic [DATA_W-1:0] CRC_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  hbStrobes_t        strb,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] shRxByte,
  output logic [DATA_W-1:0] shTxByte,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] crcData
);

  localparam int MSB = DATA_W - 1;

  logic [MSB:0] txReg;
  logic [MSB:0] txOut;
  logic [MSB:0] rxReg;
  logic [MSB:0] stageByte;
  logic [MSB:0] runCrc;
  logic [MSB:0] crcReg;
  logic [MSB:0] crcNext;
  logic [MSB:0] stageIn;

  function automatic logic [MSB:0] crcStep(input logic [MSB:0] seed,
                                           input logic [MSB:0] data);
    logic [MSB:0] acc;
    logic         fb;
    acc = seed;
    for (int i = MSB; i >= 0; i--) begin
      fb  = acc[MSB] ^ data[i];
      acc = {acc[MSB-1:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return acc;
  endfunction

  assign crcNext = crcStep(runCrc, stageByte);
  assign stageIn = (strb.stageSrc == SRC_TX) ? txOut : shRxByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
      txOut <= '0;
    end else begin
      if (strb.txLoad) txReg <= cpuWdata;
      if (strb.txMove) txOut <= txReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '0;
    end else if (strb.rxCapture) begin
      rxReg <= shRxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageByte <= '0;
      runCrc    <= CRC_INIT;
      crcReg    <= '0;
    end else begin
      if (strb.stageLoad) stageByte <= stageIn;
      if (strb.crcCommit) crcReg <= crcNext;
      if (strb.crcClear)       runCrc <= CRC_INIT;
      else if (strb.crcCommit) runCrc <= crcNext;
    end
  end

  assign shTxByte = txOut;
  assign rxData   = rxReg;
  assign crcData  = crcReg;

  // R10
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.crcCommit |=> $stable(crcReg));

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rxCapture |=> $stable(rxReg));

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.txMove |=> $stable(txOut));

endmodule

// File: rtl/iic_hostbuf_ctrl.sv
module iic_hostbuf_ctrl
  import iic_hostbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWrTx,
  input  logic       cpuRdRx,
  input  logic       cpuRdCrc,
  input  logic       shStart,
  input  logic       shLoadReq,
  input  logic       shByteSent,
  input  logic       shByteRcvd,
  input  logic       shAddrMatch,
  input  logic       shRwBit,
  input  logic       shAckSample,
  input  logic       shNack,
  output hbStrobes_t strb,
  output logic       dirTx,
  output logic       noAck,
  output logic       crcReady,
  output logic       txEmpty,
  output logic       rxFull,
  output logic       sdaRelease,
  output logic       shTxValid,
  output logic       underrun,
  output logic       overrun
);

  logic stageValid;
  logic moveNow;
  logic anyByte;

  assign moveNow = shLoadReq && !txEmpty;
  assign anyByte = shAddrMatch || shByteRcvd || shByteSent;

  always_comb begin
    strb           = '0;
    strb.txLoad    = cpuWrTx;
    strb.txMove    = moveNow;
    strb.rxCapture = shByteRcvd;
    strb.stageLoad = anyByte;
    strb.stageSrc  = (shAddrMatch || shByteRcvd) ? SRC_RX : SRC_TX;
    strb.crcCommit = stageValid;
    strb.crcClear  = shStart;
  end

  // transmit buffer state, set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmpty   <= 1'b1;
      shTxValid <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      if (moveNow)      txEmpty <= 1'b1;
      else if (cpuWrTx) txEmpty <= 1'b0;
      shTxValid <= moveNow;
      underrun  <= shLoadReq && txEmpty;
    end
  end

  // receive buffer state, set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (shByteRcvd)   rxFull <= 1'b1;
      else if (cpuRdRx) rxFull <= 1'b0;
      overrun <= shByteRcvd && rxFull;
    end
  end

  // direction and acknowledge tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirTx      <= 1'b0;
      noAck      <= 1'b1;
      sdaRelease <= 1'b0;
    end else begin
      if (shAddrMatch) dirTx <= shRwBit;
      if (shAckSample) noAck <= shNack;
      if (shAckSample && shNack)         sdaRelease <= 1'b1;
      else if (shStart || shAckSample)   sdaRelease <= 1'b0;
    end
  end

  // CRC publish pipeline, set wins over CPU read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      crcReady   <= 1'b0;
    end else begin
      stageValid <= anyByte;
      if (stageValid)    crcReady <= 1'b1;
      else if (cpuRdCrc) crcReady <= 1'b0;
    end
  end

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shAddrMatch |=> $stable(dirTx));

  // R3
  nack_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    shAckSample |=> (noAck == $past(shNack)));

  // R4
  release_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shAckSample && shNack) |=> sdaRelease);

  // R5
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrTx && !(shLoadReq && !txEmpty)) |=> !txEmpty);

  // R6
  underrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shLoadReq && txEmpty) |=> (underrun && !shTxValid));

  // R7
  rx_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    shByteRcvd |=> rxFull);

  // R8
  overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shByteRcvd && rxFull) |=> overrun);

  // R10
  crc_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyByte |=> ##1 crcReady);

endmodule

// File: rtl/iic_hostbuf.sv
module iic_hostbuf
  import iic_hostbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] CRC_POLY = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrTx,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              cpuRdRx,
  input  logic              cpuRdCrc,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] crcData,
  output logic              dirTx,
  output logic              noAck,
  output logic              crcReady,
  output logic              txEmpty,
  output logic              rxFull,
  input  logic              shStart,
  input  logic              shLoadReq,
  output logic [DATA_W-1:0] shTxByte,
  output logic              shTxValid,
  input  logic              shByteSent,
  input  logic              shByteRcvd,
  input  logic [DATA_W-1:0] shRxByte,
  input  logic              shAddrMatch,
  input  logic              shRwBit,
  input  logic              shAckSample,
  input  logic              shNack,
  output logic              sdaRelease,
  output logic              underrun,
  output logic              overrun
);

  hbStrobes_t strb;

  iic_hostbuf_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cpuWrTx    (cpuWrTx),
    .cpuRdRx    (cpuRdRx),
    .cpuRdCrc   (cpuRdCrc),
    .shStart    (shStart),
    .shLoadReq  (shLoadReq),
    .shByteSent (shByteSent),
    .shByteRcvd (shByteRcvd),
    .shAddrMatch(shAddrMatch),
    .shRwBit    (shRwBit),
    .shAckSample(shAckSample),
    .shNack     (shNack),
    .strb       (strb),
    .dirTx      (dirTx),
    .noAck      (noAck),
    .crcReady   (crcReady),
    .txEmpty    (txEmpty),
    .rxFull     (rxFull),
    .sdaRelease (sdaRelease),
    .shTxValid  (shTxValid),
    .underrun   (underrun),
    .overrun    (overrun)
  );

  iic_hostbuf_dp #(
    .DATA_W  (DATA_W),
    .CRC_POLY(CRC_POLY)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cpuWdata(cpuWdata),
    .shRxByte(shRxByte),
    .shTxByte(shTxByte),
    .rxData  (rxData),
    .crcData (crcData)
  );

endmodule

// File: tb/iic_hostbuf_tb_top.sv
module iic_hostbuf_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic       cpuWrTx, cpuRdRx, cpuRdCrc;
  logic [7:0] cpuWdata, shRxByte;
  logic       shStart, shLoadReq, shByteSent, shByteRcvd;
  logic       shAddrMatch, shRwBit, shAckSample, shNack;
  logic [7:0] rxData, crcData, shTxByte;
  logic       dirTx, noAck, crcReady, txEmpty, rxFull;
  logic       shTxValid, sdaRelease, underrun, overrun;

  iic_hostbuf dut_i (
    .clk(clk), .rstN(rstN), .cpuWrTx(cpuWrTx), .cpuWdata(cpuWdata),
    .cpuRdRx(cpuRdRx), .cpuRdCrc(cpuRdCrc), .rxData(rxData), .crcData(crcData),
    .dirTx(dirTx), .noAck(noAck), .crcReady(crcReady), .txEmpty(txEmpty),
    .rxFull(rxFull), .shStart(shStart), .shLoadReq(shLoadReq),
    .shTxByte(shTxByte), .shTxValid(shTxValid), .shByteSent(shByteSent),
    .shByteRcvd(shByteRcvd), .shRxByte(shRxByte), .shAddrMatch(shAddrMatch),
    .shRwBit(shRwBit), .shAckSample(shAckSample), .shNack(shNack),
    .sdaRelease(sdaRelease), .underrun(underrun), .overrun(overrun)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  // reference model state
  logic [7:0] mTxReg, mShTx, mRx, mStage, mRun, mCrc;
  logic       mStageV, mTxE, mRxF, mCrcR, mDir, mNoAck, mRel, mTxV, mUnder, mOver;

  function automatic logic [7:0] crc8(input logic [7:0] seed, input logic [7:0] d);
    logic [7:0] c = seed;
    for (int i = 7; i >= 0; i--) begin
      if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R5",  "txEmpty",    {7'd0, txEmpty},    {7'd0, mTxE});
    chk("R5",  "shTxValid",  {7'd0, shTxValid},  {7'd0, mTxV});
    chk("R5",  "shTxByte",   shTxByte,           mShTx);
    chk("R6",  "underrun",   {7'd0, underrun},   {7'd0, mUnder});
    chk("R7",  "rxFull",     {7'd0, rxFull},     {7'd0, mRxF});
    chk("R7",  "rxData",     rxData,             mRx);
    chk("R8",  "overrun",    {7'd0, overrun},    {7'd0, mOver});
    chk("R2",  "dirTx",      {7'd0, dirTx},      {7'd0, mDir});
    chk("R3",  "noAck",      {7'd0, noAck},      {7'd0, mNoAck});
    chk("R4",  "sdaRelease", {7'd0, sdaRelease}, {7'd0, mRel});
    chk("R9",  "crcData",    crcData,            mCrc);
    chk("R11", "crcReady",   {7'd0, crcReady},   {7'd0, mCrcR});
  endtask

  task automatic idleIn();
    cpuWrTx = 0; cpuWdata = 0; cpuRdRx = 0; cpuRdCrc = 0;
    shStart = 0; shLoadReq = 0; shByteSent = 0; shByteRcvd = 0;
    shRxByte = 0; shAddrMatch = 0; shRwBit = 0; shAckSample = 0; shNack = 0;
  endtask

  task automatic modelReset();
    mTxReg = 0; mShTx = 0; mRx = 0; mStage = 0; mRun = 0; mCrc = 0;
    mStageV = 0; mTxE = 1; mRxF = 0; mCrcR = 0; mDir = 0; mNoAck = 1;
    mRel = 0; mTxV = 0; mUnder = 0; mOver = 0;
  endtask

  // inputs are already driven; advance one edge and compare
  task automatic step();
    logic move, nTxE, nRxF, nCrcR, nRel, nStageV;
    logic [7:0] nShTx, nStage, nRun, nCrc, cNext;
    move   = shLoadReq && !mTxE;
    cNext  = crc8(mRun, mStage);
    nShTx  = move ? mTxReg : mShTx;
    nTxE   = move ? 1'b1 : (cpuWrTx ? 1'b0 : mTxE);
    nRxF   = shByteRcvd ? 1'b1 : (cpuRdRx ? 1'b0 : mRxF);
    nCrcR  = mStageV ? 1'b1 : (cpuRdCrc ? 1'b0 : mCrcR);
    nRel   = (shAckSample && shNack) ? 1'b1 : ((shStart || shAckSample) ? 1'b0 : mRel);
    nStageV = shAddrMatch || shByteRcvd || shByteSent;
    nStage = (shAddrMatch || shByteRcvd) ? shRxByte : (shByteSent ? mShTx : mStage);
    nCrc   = mStageV ? cNext : mCrc;
    nRun   = shStart ? 8'h00 : (mStageV ? cNext : mRun);
    mUnder = shLoadReq && mTxE;
    mOver  = shByteRcvd && mRxF;
    mTxV   = move;
    if (cpuWrTx) mTxReg = cpuWdata;
    if (shByteRcvd) mRx = shRxByte;
    if (shAddrMatch) mDir = shRwBit;
    if (shAckSample) mNoAck = shNack;
    mShTx = nShTx; mTxE = nTxE; mRxF = nRxF; mCrcR = nCrcR; mRel = nRel;
    mStageV = nStageV; mStage = nStage; mCrc = nCrc; mRun = nRun;
    @(negedge clk);
    compareAll();
    idleIn();
  endtask

  task automatic randomIn();
    int ev;
    idleIn();
    ev = $urandom_range(0, 7);
    shAddrMatch = (ev == 0);
    shByteRcvd  = (ev == 1);
    shByteSent  = (ev == 2);
    shRxByte    = 8'($urandom);
    shRwBit     = 1'($urandom);
    cpuWrTx     = ($urandom_range(0, 3) == 0);
    cpuWdata    = 8'($urandom);
    cpuRdRx     = ($urandom_range(0, 3) == 0);
    cpuRdCrc    = ($urandom_range(0, 3) == 0);
    shLoadReq   = ($urandom_range(0, 4) == 0);
    shAckSample = ($urandom_range(0, 5) == 0);
    shNack      = 1'($urandom);
    shStart     = ($urandom_range(0, 19) == 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    idleIn();
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk("R1", "txEmpty",  {7'd0, txEmpty},  8'd1);
    chk("R1", "noAck",    {7'd0, noAck},    8'd1);
    chk("R1", "rxFull",   {7'd0, rxFull},   8'd0);
    chk("R1", "crcReady", {7'd0, crcReady}, 8'd0);
    chk("R1", "dirTx",    {7'd0, dirTx},    8'd0);
    chk("R1", "crcData",  crcData,          8'd0);
    compareAll();

    // R2 R9 R10: address 0x01 with read bit, CRC 0x07 only after second edge
    shAddrMatch = 1; shRxByte = 8'h01; shRwBit = 1;
    step();
    chk("R10", "crcReady early", {7'd0, crcReady}, 8'd0);
    chk("R2",  "dirTx read",     {7'd0, dirTx},    8'd1);
    step();
    chk("R10", "crcReady late", {7'd0, crcReady}, 8'd1);
    chk("R9",  "crc of 0x01",   crcData,          8'h07);

    // R11: read of CRC colliding with a new publish keeps ready
    shByteRcvd = 1; shRxByte = 8'hA5;
    step();
    cpuRdCrc = 1;
    step();
    chk("R11", "set wins", {7'd0, crcReady}, 8'd1);
    cpuRdCrc = 1;
    step();
    chk("R11", "read clears", {7'd0, crcReady}, 8'd0);

    // R8: second byte without read overwrites and flags overrun
    shByteRcvd = 1; shRxByte = 8'h3C;
    step();
    chk("R8", "overrun pulse", {7'd0, overrun}, 8'd1);
    chk("R8", "overwrite",     rxData,          8'h3C);
    step();
    chk("R8", "pulse ends", {7'd0, overrun}, 8'd0);

    // R6: load request with nothing buffered
    shLoadReq = 1;
    step();
    chk("R6", "underrun", {7'd0, underrun}, 8'd1);

    // R5: CRC copied into transmit path and sent
    cpuWrTx = 1; cpuWdata = crcData;
    step();
    shLoadReq = 1;
    step();
    chk("R5", "crc byte to shifter", shTxByte, mCrc);

    // R9: start pulse clears the running value
    shStart = 1;
    step();
    shAddrMatch = 1; shRxByte = 8'h01; shRwBit = 0;
    step();
    step();
    chk("R9", "restart crc", crcData, 8'h07);

    // R3 R4: nack then ack sampling
    shAckSample = 1; shNack = 1;
    step();
    chk("R4", "release on nack", {7'd0, sdaRelease}, 8'd1);
    shAckSample = 1; shNack = 0;
    step();
    chk("R3", "ack clears", {7'd0, noAck}, 8'd0);

    // random mix, all requirements via the model
    for (int n = 0; n < 4000; n++) begin
      randomIn();
      step();
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule